// File: doc/BRIEF.md
# Banked Control Register Block for a Multi-Channel Line Interface

This block is the host-visible register file of an eight-channel line interface controller. The host reaches it over a simple parallel bus: a 5-bit address, an 8-bit write bus, and separate one-cycle read and write strobes. Only 32 addresses are available. One of four register banks is mapped onto the lower 31 of them, and the topmost address (1Fh) holds a bank pointer that stays reachable whatever bank is selected. The four banks are a primary bank, a secondary bank, a per-channel bank and a test-counter bank. They are chosen by the pointer codes 00h, AAh, 01h and 02h. Every other code leaves the lower addresses unmapped.

The per-channel bank drives three independent eight-bit control vectors: jitter attenuator enable, receive clock inversion and transmit clock inversion. It also holds a line-violation status register fed by per-channel event inputs, a mask for that register, and an interrupt control register. That control register selects whether status bits clear when the status is read or when it is written. A single registered interrupt output reports any unmasked status bit.

The bank selection is a small state machine with the states BANK_PRI, BANK_SEC, BANK_CHN, BANK_TST and BANK_NONE. Reset enters BANK_PRI. A write to address 1Fh is the only transition: it moves from any state to the state that the written code decodes to, and any undefined code leads to BANK_NONE. The status bits of each channel have two states, clear and set. An event makes the transition clear→set. The clear access selected by the mode makes the transition set→clear, unless an event arrives in the same cycle.

Top module: `lineif_regbank`

## Requirements
- R1: After reset the pointer reads 00h and the primary bank is selected. All status bits, masks and control outputs are 0. The clear mode is clear-on-read, `irq` is 0 and `rvalid` is 0.
- R2: A write to address 1Fh loads the pointer in every bank, including the unmapped state. A read of 1Fh returns the last value written there.
- R3: Pointer code 00h selects the primary bank, AAh the secondary bank, 01h the per-channel bank and 02h the test-counter bank. Each bank keeps its own contents. With any other code, reads below 1Fh return 00h and writes below 1Fh change nothing.
- R4: The primary bank implements 00h–15h, the secondary bank 00h–06h and the test-counter bank 00h–07h as read/write byte registers. Their other addresses below 1Fh read 00h and ignore writes.
- R5: In the per-channel bank, 00h drives `ja_en`, 01h drives `rx_clk_inv` and 02h drives `tx_clk_inv`, with bit n controlling channel n. The outputs take the written value on the clock edge of the write.
- R6: A high `lv_event[n]` at a clock edge sets bit n of the line-violation status at per-channel address 12h. The bit stays set until it is cleared.
- R7: When bit 0 of per-channel address 1Eh is 0 (clear-on-read), a read of 12h returns the status as it was before the read and clears all of its bits. Writes to 12h have no effect.
- R8: When bit 0 of 1Eh is 1 (clear-on-write), writing 12h clears each status bit whose data bit is 1 and leaves the bits whose data bit is 0. Reads do not clear.
- R9: An event on a channel in the same cycle as a clear access leaves that channel's status bit set.
- R10: `irq` is the registered OR of (status AND NOT mask), where the mask is at per-channel address 03h and a 1 masks the channel. It follows a status change one clock later.
- R11: Read data appears on `rdata` with `rvalid` high one clock after `rd_en`. When `rd_en` and `wr_en` are high together, the write is performed and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rdata | output | 8 | Registered read data |
| rvalid | output | 1 | High for one cycle when `rdata` holds a fresh result |
| lv_event | input | 8 | Per-channel line-violation event pulses |
| ja_en | output | 8 | Per-channel jitter attenuator enable |
| rx_clk_inv | output | 8 | Per-channel receive clock inversion |
| tx_clk_inv | output | 8 | Per-channel transmit clock inversion |
| irq | output | 1 | Interrupt, registered OR of unmasked status |

## Verification
A line-violation event and a clear of the same status bit can land in one clock edge. The bench provokes this by driving `lv_event` in the same cycle as a read strobe on 12h in clear-on-read mode, and again with a write strobe in clear-on-write mode. It judges the result by the read data of that access and by the value that the next status read returns. A second collision is a read strobe and a write strobe issued together. The bench checks this through the absence of `rvalid` and the read-back of the written register.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

    typedef enum logic [2:0] {
        BANK_PRI,
        BANK_SEC,
        BANK_CHN,
        BANK_TST,
        BANK_NONE
    } bank_e;

    localparam logic [7:0] PTR_PRI = 8'h00;
    localparam logic [7:0] PTR_SEC = 8'hAA;
    localparam logic [7:0] PTR_CHN = 8'h01;
    localparam logic [7:0] PTR_TST = 8'h02;

    function automatic bank_e decode_ptr(input logic [7:0] code);
        bank_e b;
        case (code)
            PTR_PRI: b = BANK_PRI;
            PTR_SEC: b = BANK_SEC;
            PTR_CHN: b = BANK_CHN;
            PTR_TST: b = BANK_TST;
            default: b = BANK_NONE;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lrb_bank_fsm.sv
module lrb_bank_fsm
    import lrb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ptr_q,
    output logic          sel_pri,
    output logic          sel_sec,
    output logic          sel_chn,
    output logic          sel_tst
);

    bank_e state_q, state_d;

    // next state: a pointer write is the only transition
    always_comb begin
        state_d = state_q;
        if (ptr_we) state_d = decode_ptr(8'(wdata));
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BANK_PRI;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (ptr_we) ptr_q <= wdata;
        end
    end

    // outputs
    always_comb begin
        sel_pri = 1'b0;
        sel_sec = 1'b0;
        sel_chn = 1'b0;
        sel_tst = 1'b0;
        unique case (state_q)
            BANK_PRI:  sel_pri = 1'b1;
            BANK_SEC:  sel_sec = 1'b1;
            BANK_CHN:  sel_chn = 1'b1;
            BANK_TST:  sel_tst = 1'b1;
            BANK_NONE: ;
            default:   ;
        endcase
    end

    assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |=> (ptr_q == $past(wdata)));

    assert_undef_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && (8'(wdata) != PTR_PRI) && (8'(wdata) != PTR_SEC) &&
         (8'(wdata) != PTR_CHN) && (8'(wdata) != PTR_TST))
        |=> !(sel_pri || sel_sec || sel_chn || sel_tst));

    assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_pri, sel_sec, sel_chn, sel_tst}));

endmodule

// File: rtl/lrb_regfile.sv
module lrb_regfile #(
    parameter int DEPTH = 22,
    parameter int AW    = 5,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[i] <= '0;
            else if (sel && we && (addr == AW'(i)))
                mem_q[i] <= wdata;
        end
    end

    // addresses at or above DEPTH are reserved and read as zero
    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++)
            if (sel && (addr == AW'(i))) rdata = mem_q[i];
    end

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(addr) >= DEPTH) |-> (rdata == '0));

endmodule

// File: rtl/lrb_chan_bank.sv
module lrb_chan_bank #(
    parameter int NCH = 8,
    parameter int AW  = 5,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel,
    input  logic           we,
    input  logic           re,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    input  logic [NCH-1:0] ev,
    output logic [DW-1:0]  rdata,
    output logic [NCH-1:0] ja_en,
    output logic [NCH-1:0] rx_inv,
    output logic [NCH-1:0] tx_inv,
    output logic           irq
);

    localparam logic [AW-1:0] A_JA    = AW'(5'h00);
    localparam logic [AW-1:0] A_RXINV = AW'(5'h01);
    localparam logic [AW-1:0] A_TXINV = AW'(5'h02);
    localparam logic [AW-1:0] A_MASK  = AW'(5'h03);
    localparam logic [AW-1:0] A_LVS   = AW'(5'h12);
    localparam logic [AW-1:0] A_ICTL  = AW'(5'h1E);

    logic [NCH-1:0] ja_q, rxi_q, txi_q, mask_q, stat_q;
    logic           cow_q;
    logic           irq_q;
    logic           wr_hit_lvs, rd_hit_lvs, clr_rd, clr_wr;

    assign wr_hit_lvs = sel && we && (addr == A_LVS);
    assign rd_hit_lvs = sel && re && (addr == A_LVS);
    assign clr_rd     = rd_hit_lvs && !cow_q;
    assign clr_wr     = wr_hit_lvs && cow_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ja_q   <= '0;
            rxi_q  <= '0;
            txi_q  <= '0;
            mask_q <= '0;
            cow_q  <= 1'b0;
        end else if (sel && we) begin
            case (addr)
                A_JA:    ja_q   <= wdata[NCH-1:0];
                A_RXINV: rxi_q  <= wdata[NCH-1:0];
                A_TXINV: txi_q  <= wdata[NCH-1:0];
                A_MASK:  mask_q <= wdata[NCH-1:0];
                A_ICTL:  cow_q  <= wdata[0];
                default: ;
            endcase
        end
    end

    // per-channel status: event beats clear
    for (genvar ch = 0; ch < NCH; ch++) begin : g_stat
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_q[ch] <= 1'b0;
            else if (ev[ch])
                stat_q[ch] <= 1'b1;
            else if (clr_rd || (clr_wr && wdata[ch]))
                stat_q[ch] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(stat_q & ~mask_q);
    end

    always_comb begin
        rdata = '0;
        if (sel) begin
            case (addr)
                A_JA:    rdata = DW'(ja_q);
                A_RXINV: rdata = DW'(rxi_q);
                A_TXINV: rdata = DW'(txi_q);
                A_MASK:  rdata = DW'(mask_q);
                A_LVS:   rdata = DW'(stat_q);
                A_ICTL:  rdata = DW'(cow_q);
                default: rdata = '0;
            endcase
        end
    end

    assign ja_en  = ja_q;
    assign rx_inv = rxi_q;
    assign tx_inv = txi_q;
    assign irq    = irq_q;

    assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(ev)) == $past(ev)));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && re && (addr == A_LVS) && !cow_q) |=> (stat_q == $past(ev)));

    assert_read_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && re && !we && cow_q) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && we && (addr == A_LVS) && cow_q && ((wdata[NCH-1:0] & ev) != '0))
        |=> ((stat_q & $past(ev)) != '0));

    assert_irq_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(stat_q & ~mask_q))));

endmodule

// File: rtl/lineif_regbank.sv
module lineif_regbank
    import lrb_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int AW        = 5,
    parameter int DW        = 8,
    parameter int PRI_DEPTH = 22,
    parameter int SEC_DEPTH = 7,
    parameter int TST_DEPTH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    input  logic           wr_en,
    input  logic           rd_en,
    output logic [DW-1:0]  rdata,
    output logic           rvalid,
    input  logic [NCH-1:0] lv_event,
    output logic [NCH-1:0] ja_en,
    output logic [NCH-1:0] rx_clk_inv,
    output logic [NCH-1:0] tx_clk_inv,
    output logic           irq
);

    localparam logic [AW-1:0] A_PTR = '1;

    logic          hit_ptr, rd_ok, bank_we;
    logic [DW-1:0] ptr_q;
    logic          sel_pri, sel_sec, sel_chn, sel_tst;
    logic [DW-1:0] pri_rd, sec_rd, tst_rd, chn_rd, rd_mux;
    logic [DW-1:0] rdata_q;
    logic          rvalid_q;

    assign hit_ptr = (addr == A_PTR);
    assign rd_ok   = rd_en && !wr_en;
    assign bank_we = wr_en && !hit_ptr;

    lrb_bank_fsm #(.DW(DW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_we  (wr_en && hit_ptr),
        .wdata   (wdata),
        .ptr_q   (ptr_q),
        .sel_pri (sel_pri),
        .sel_sec (sel_sec),
        .sel_chn (sel_chn),
        .sel_tst (sel_tst)
    );

    lrb_regfile #(.DEPTH(PRI_DEPTH), .AW(AW), .DW(DW)) u_pri (
        .clk(clk), .rst_n(rst_n), .sel(sel_pri), .we(bank_we),
        .addr(addr), .wdata(wdata), .rdata(pri_rd)
    );

    lrb_regfile #(.DEPTH(SEC_DEPTH), .AW(AW), .DW(DW)) u_sec (
        .clk(clk), .rst_n(rst_n), .sel(sel_sec), .we(bank_we),
        .addr(addr), .wdata(wdata), .rdata(sec_rd)
    );

    lrb_regfile #(.DEPTH(TST_DEPTH), .AW(AW), .DW(DW)) u_tst (
        .clk(clk), .rst_n(rst_n), .sel(sel_tst), .we(bank_we),
        .addr(addr), .wdata(wdata), .rdata(tst_rd)
    );

    lrb_chan_bank #(.NCH(NCH), .AW(AW), .DW(DW)) u_chn (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel_chn && !hit_ptr),
        .we     (wr_en),
        .re     (rd_ok),
        .addr   (addr),
        .wdata  (wdata),
        .ev     (lv_event),
        .rdata  (chn_rd),
        .ja_en  (ja_en),
        .rx_inv (rx_clk_inv),
        .tx_inv (tx_clk_inv),
        .irq    (irq)
    );

    always_comb begin
        if (hit_ptr) rd_mux = ptr_q;
        else         rd_mux = pri_rd | sec_rd | tst_rd | chn_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_ok;
            if (rd_ok) rdata_q <= rd_mux;
        end
    end

    assign rdata  = rdata_q;
    assign rvalid = rvalid_q;

    assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && !hit_ptr && !(sel_pri || sel_sec || sel_chn || sel_tst))
        |=> (rdata == '0));

    assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rvalid == !$past(wr_en)));

    assert_ptr_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && hit_ptr) |=> (rdata == $past(ptr_q)));

endmodule

// File: tb/tb_lineif_regbank.sv
module tb_lineif_regbank;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] addr;
    logic [7:0] wdata;
    logic       wr_en, rd_en;
    logic [7:0] rdata;
    logic       rvalid;
    logic [7:0] lv_event;
    logic [7:0] ja_en, rx_clk_inv, tx_clk_inv;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    lineif_regbank dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .rvalid(rvalid),
        .lv_event(lv_event), .ja_en(ja_en), .rx_clk_inv(rx_clk_inv),
        .tx_clk_inv(tx_clk_inv), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic [7:0] ev = 8'h00);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; lv_event = ev;
        @(negedge clk);
        wr_en = 1'b0; lv_event = 8'h00;
    endtask

    task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag,
                      input logic [7:0] ev = 8'h00);
        @(negedge clk);
        addr = a; rd_en = 1'b1; lv_event = ev;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0; lv_event = 8'h00;
    endtask

    task automatic pulse_ev(input logic [7:0] ev);
        @(negedge clk);
        lv_event = ev;
        @(negedge clk);
        lv_event = 8'h00;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n === 1'b1 && rvalid === 1'b1) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R11: unexpected rvalid, actual=%0h expected=none", rdata);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                chk(t, 32'(rdata), 32'(e));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 0; rd_en = 0; lv_event = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 rvalid", 32'(rvalid), 0);
        chk("R1 ja_en", 32'(ja_en), 0);
        chk("R1 clk_inv", 32'({rx_clk_inv, tx_clk_inv}), 0);
        rd(5'h1F, 8'h00, "R1 pointer");

        // R4 primary bank
        wr(5'h00, 8'h5A);
        wr(5'h15, 8'hC3);
        wr(5'h16, 8'hFF);
        wr(5'h1E, 8'h11);
        rd(5'h00, 8'h5A, "R4 pri 00");
        rd(5'h15, 8'hC3, "R4 pri 15");
        rd(5'h16, 8'h00, "R4 pri 16 reserved");
        rd(5'h1E, 8'h00, "R4 pri 1E reserved");

        // R2/R3 secondary bank
        wr(5'h1F, 8'hAA);
        rd(5'h1F, 8'hAA, "R2 pointer AA");
        rd(5'h00, 8'h00, "R3 secondary separate");
        wr(5'h06, 8'h77);
        wr(5'h07, 8'h99);
        rd(5'h06, 8'h77, "R4 sec 06");
        rd(5'h07, 8'h00, "R4 sec 07 reserved");

        // R3 undefined code
        wr(5'h1F, 8'h55);
        wr(5'h00, 8'hEE);
        wr(5'h06, 8'h12);
        rd(5'h06, 8'h00, "R3 unmapped read");
        rd(5'h1F, 8'h55, "R2 pointer in unmapped state");
        wr(5'h1F, 8'hAA);
        rd(5'h06, 8'h77, "R3 unmapped write ignored");
        rd(5'h00, 8'h00, "R3 unmapped write ignored 00");
        wr(5'h1F, 8'h00);
        rd(5'h00, 8'h5A, "R3 primary kept");

        // test-counter bank
        wr(5'h1F, 8'h02);
        wr(5'h07, 8'h3C);
        wr(5'h08, 8'h44);
        rd(5'h07, 8'h3C, "R4 tst 07");
        rd(5'h08, 8'h00, "R4 tst 08 reserved");

        // R5 per-channel controls
        wr(5'h1F, 8'h01);
        rd(5'h1F, 8'h01, "R2 pointer 01");
        wr(5'h00, 8'hA5);
        chk("R5 ja_en", 32'(ja_en), 32'h0A5);
        wr(5'h01, 8'h0F);
        chk("R5 rx_clk_inv", 32'(rx_clk_inv), 32'h0F);
        wr(5'h02, 8'hF0);
        chk("R5 tx_clk_inv", 32'(tx_clk_inv), 32'hF0);
        chk("R5 ja_en independent", 32'(ja_en), 32'hA5);
        rd(5'h00, 8'hA5, "R5 ja readback");

        // R6 / R10 event and irq timing
        @(negedge clk); lv_event = 8'h81;
        @(negedge clk); lv_event = 8'h00;
        chk("R10 irq lag", 32'(irq), 0);
        @(negedge clk);
        chk("R10 irq set", 32'(irq), 1);
        repeat (3) @(negedge clk);
        rd(5'h12, 8'h81, "R6 status held");
        @(negedge clk);
        chk("R10 irq cleared", 32'(irq), 0);
        rd(5'h12, 8'h00, "R7 read cleared");

        // R7 write ignored in clear-on-read mode
        pulse_ev(8'h04);
        wr(5'h12, 8'hFF);
        rd(5'h12, 8'h04, "R7 write no effect");
        rd(5'h12, 8'h00, "R7 cleared after read");

        // R10 mask
        wr(5'h03, 8'h01);
        pulse_ev(8'h01);
        repeat (2) @(negedge clk);
        chk("R10 masked irq", 32'(irq), 0);
        rd(5'h12, 8'h01, "R10 masked status still set");
        wr(5'h03, 8'h00);

        // R8 clear-on-write
        wr(5'h1E, 8'h01);
        rd(5'h1E, 8'h01, "R8 mode readback");
        pulse_ev(8'h06);
        rd(5'h12, 8'h06, "R8 read no clear a");
        rd(5'h12, 8'h06, "R8 read no clear b");
        wr(5'h12, 8'h02);
        rd(5'h12, 8'h04, "R8 write-one clears");

        // R9 event during write clear
        wr(5'h12, 8'h04, 8'h04);
        rd(5'h12, 8'h04, "R9 event beats write clear");

        // R9 event during read clear
        wr(5'h1E, 8'h00);
        rd(5'h12, 8'h04, "R9 read returns pre-clear", 8'h10);
        rd(5'h12, 8'h10, "R9 event beats read clear");
        rd(5'h12, 8'h00, "R7 cleared");

        // R11 simultaneous read and write
        @(negedge clk);
        addr = 5'h00; wdata = 8'h3C; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R11 read dropped", 32'(rvalid), 0);
        chk("R11 write done", 32'(ja_en), 32'h3C);
        rd(5'h00, 8'h3C, "R11 readback");

        repeat (3) @(negedge clk);
        chk("R11 scoreboard drained", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule